// File: doc/BRIEF.md
# Per-Cycle DMA Clock Rate Switcher

This block produces two clock enables from a fast reference clock and three phase signals: one for a SCSI protocol chip and one for a DMA controller. A mode input turns the speed-up on. While it is off, both enables run at the normal rate. While it is on, the SCSI chip runs at double rate all the time. The DMA controller runs at double rate only in the late bus states of a DMA write that targets fast memory.

For DMA cycles to fast memory, the block also raises an override request and an early local acknowledge. These let the board end such cycles on its own timing instead of the host's. Both outputs are active high, and board drivers turn them into the open-collector bus lines. A change of rate waits for the next boundary where the normal and double-rate enables fall together, so the DMA controller never sees a shortened clock period.

The phase inputs follow a fixed pattern. The normal-rate level is the XNOR of phase A and phase B. The double-rate level is the XNOR of the normal-rate level and phase C. Each rising edge of a level yields a one-clock enable pulse, so normal pulses come every 4 reference clocks and double-rate pulses every 2.

Top module: `dma_rate_switch`

## Requirements
- R1: While reset is asserted, all four outputs are low.
- R2: With `fast_mode` low, both `scsi_clk_en` and `dma_clk_en` pulse once per normal period (every 4 reference clocks), whatever the bus inputs are.
- R3: With `fast_mode` high, `scsi_clk_en` pulses once every 2 reference clocks.
- R4: With `fast_mode` high, `dma_clk_en` pulses every 2 reference clocks only when all of these hold: `bus_own_n` = 0, `bus_rd` = 0 (write), `addr_hi` is in 1..4 (range 0x200000 to 0x9FFFFF), and `bus_state` is in 4..7.
- R5: In every other case (read, slave cycle with `bus_own_n` = 1, `addr_hi` of 0, 5, 6 or 7, or `bus_state` below 4), `dma_clk_en` stays at one pulse per normal period.
- R6: A DMA rate change takes effect only at a normal-period boundary. Consecutive `dma_clk_en` pulses are always 2 or 4 clocks apart. A double-rate request raised in mid-period adds no mid-period pulse until the following period.
- R7: `ovr_req` is high one clock after `fast_mode` = 1, `bus_own_n` = 0 and `addr_hi` in 1..4 hold, for reads and writes and for any bus state.
- R8: `ack_req` is high one clock after the R7 conditions hold together with `bus_state` of 4 or above, and is low for earlier states.
- R9: `ovr_req` and `ack_req` fall within one normal period once the qualifying condition ends.
- R10: Neither enable output is ever high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock (four per normal period) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ph_a | input | 1 | Sampled phase A |
| ph_b | input | 1 | Sampled phase B, in quadrature with phase A |
| ph_c | input | 1 | Sampled phase C, normal-rate signal offset a quarter period |
| fast_mode | input | 1 | Mode jumper: 1 enables double-rate operation |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_own_n | input | 1 | Active-low: the DMA controller owns the bus |
| addr_hi | input | 3 | Address bits 23 down to 21 |
| bus_state | input | 3 | Current bus state number S0..S7 |
| scsi_clk_en | output | 1 | Clock enable for the SCSI chip |
| dma_clk_en | output | 1 | Clock enable for the DMA controller |
| ovr_req | output | 1 | Override request, active high |
| ack_req | output | 1 | Local transfer acknowledge, active high |

## Verification
The override and acknowledge outputs follow a bus input one reference clock later. An enable pulse appears two clocks after the reference phase edge that causes it, and a DMA rate request is applied at the following normal boundary, so it takes effect up to five clocks after the request. The rate checks therefore wait 12 clocks after each bus change and then count pulses over a 32-clock window. That window holds exactly 8 normal or 16 double-rate pulses at any alignment. The mid-period probe changes the bus two clocks after a boundary. It then samples the DMA enable at exactly 2, 4 and 6 clocks later, where an immediate switch would already show an extra pulse.

// File: rtl/dmarate_pkg.sv
package dmarate_pkg;

  // Classification of the current bus cycle, produced by the qualifier
  typedef struct packed {
    logic dma;   // bus owned by the DMA controller
    logic fast;  // address falls in the fast-memory window
    logic wr;    // write direction
    logic late;  // bus state in the second half of the cycle
  } cyc_class_t;

endpackage

// File: rtl/rate_phase_decode.sv
module rate_phase_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_a,
  input  logic ph_b,
  input  logic ph_c,
  output logic norm_tick,
  output logic dbl_tick
);

  logic [2:0] ph_q, ph_nx;
  logic       n_lvl, d_lvl;
  logic       n_d_q, n_d_nx;
  logic       d_d_q, d_d_nx;

  // Derived levels from the captured phases
  assign n_lvl = ~(ph_q[2] ^ ph_q[1]);
  assign d_lvl = ~(n_lvl ^ ph_q[0]);

  always_comb begin
    ph_nx  = {ph_a, ph_b, ph_c};
    n_d_nx = n_lvl;
    d_d_nx = d_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      n_d_q <= 1'b1;   // held high so no edge is seen right after reset
      d_d_q <= 1'b1;
    end else begin
      ph_q  <= ph_nx;
      n_d_q <= n_d_nx;
      d_d_q <= d_d_nx;
    end
  end

  assign norm_tick = n_lvl & ~n_d_q;
  assign dbl_tick  = d_lvl & ~d_d_q;

endmodule

// File: rtl/rate_cycle_qualify.sv
module rate_cycle_qualify
  import dmarate_pkg::*;
#(
  parameter int REG_W      = 3,
  parameter int ST_W       = 3,
  parameter int REGION_LO  = 1,
  parameter int REGION_HI  = 4,
  parameter int LATE_FIRST = 4
) (
  input  logic              bus_rd,
  input  logic              bus_own_n,
  input  logic [REG_W-1:0]  addr_hi,
  input  logic [ST_W-1:0]   bus_state,
  output cyc_class_t        cls,
  output logic              want_dbl
);

  localparam logic [REG_W-1:0] LO_V   = REG_W'(REGION_LO);
  localparam logic [REG_W-1:0] HI_V   = REG_W'(REGION_HI);
  localparam logic [ST_W-1:0]  LATE_V = ST_W'(LATE_FIRST);

  always_comb begin
    cls.dma  = ~bus_own_n;
    cls.fast = (addr_hi >= LO_V) && (addr_hi <= HI_V);
    cls.wr   = ~bus_rd;
    cls.late = (bus_state >= LATE_V);
    want_dbl = cls.dma & cls.fast & cls.wr & cls.late;
  end

endmodule

// File: rtl/rate_select.sv
module rate_select (
  input  logic clk,
  input  logic rst_n,
  input  logic norm_tick,
  input  logic dbl_tick,
  input  logic fast_mode,
  input  logic want_dbl,
  output logic scsi_en,
  output logic dma_en,
  output logic rate_sel
);

  logic mode_q, mode_nx;
  logic sel_q, sel_nx;
  logic scsi_q, scsi_nx;
  logic dma_q, dma_nx;

  // Selections change only on a coincident boundary
  always_comb begin
    mode_nx = norm_tick ? fast_mode : mode_q;
    sel_nx  = norm_tick ? (fast_mode & want_dbl) : sel_q;
    scsi_nx = mode_q ? dbl_tick : norm_tick;
    dma_nx  = sel_q  ? dbl_tick : norm_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      sel_q  <= 1'b0;
      scsi_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      mode_q <= mode_nx;
      sel_q  <= sel_nx;
      scsi_q <= scsi_nx;
      dma_q  <= dma_nx;
    end
  end

  assign scsi_en  = scsi_q;
  assign dma_en   = dma_q;
  assign rate_sel = sel_q;

endmodule

// File: rtl/rate_local_ack.sv
module rate_local_ack
  import dmarate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_mode,
  input  cyc_class_t cls,
  output logic       ovr_req,
  output logic       ack_req
);

  logic ovr_q, ovr_nx;
  logic ack_q, ack_nx;

  always_comb begin
    ovr_nx = fast_mode & cls.dma & cls.fast;
    ack_nx = ovr_nx & cls.late;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      ovr_q <= ovr_nx;
      ack_q <= ack_nx;
    end
  end

  assign ovr_req = ovr_q;
  assign ack_req = ack_q;

endmodule

// File: rtl/dma_rate_switch.sv
module dma_rate_switch
  import dmarate_pkg::*;
#(
  parameter int REG_W      = 3,
  parameter int ST_W       = 3,
  parameter int REGION_LO  = 1,
  parameter int REGION_HI  = 4,
  parameter int LATE_FIRST = 4,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph_a,
  input  logic             ph_b,
  input  logic             ph_c,
  input  logic             fast_mode,
  input  logic             bus_rd,
  input  logic             bus_own_n,
  input  logic [REG_W-1:0] addr_hi,
  input  logic [ST_W-1:0]  bus_state,
  output logic             scsi_clk_en,
  output logic             dma_clk_en,
  output logic             ovr_req,
  output logic             ack_req
);

  logic [RST_STAGES-1:0] rs_q;
  logic                  rst_n_s;
  logic                  norm_tick, dbl_tick;
  logic                  want_dbl, rate_sel;
  cyc_class_t            cls;

  // Reset release synchronizer
  generate
    if (RST_STAGES == 1) begin : g_rs1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= 1'b1;
      end
    end else begin : g_rsn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_s = rs_q[RST_STAGES-1];

  rate_phase_decode u_phase (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ph_a      (ph_a),
    .ph_b      (ph_b),
    .ph_c      (ph_c),
    .norm_tick (norm_tick),
    .dbl_tick  (dbl_tick)
  );

  rate_cycle_qualify #(
    .REG_W      (REG_W),
    .ST_W       (ST_W),
    .REGION_LO  (REGION_LO),
    .REGION_HI  (REGION_HI),
    .LATE_FIRST (LATE_FIRST)
  ) u_qual (
    .bus_rd    (bus_rd),
    .bus_own_n (bus_own_n),
    .addr_hi   (addr_hi),
    .bus_state (bus_state),
    .cls       (cls),
    .want_dbl  (want_dbl)
  );

  rate_select u_sel (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .norm_tick (norm_tick),
    .dbl_tick  (dbl_tick),
    .fast_mode (fast_mode),
    .want_dbl  (want_dbl),
    .scsi_en   (scsi_clk_en),
    .dma_en    (dma_clk_en),
    .rate_sel  (rate_sel)
  );

  rate_local_ack u_ack (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .fast_mode (fast_mode),
    .cls       (cls),
    .ovr_req   (ovr_req),
    .ack_req   (ack_req)
  );

endmodule

// File: rtl/rate_switch_chk.sv
module rate_switch_chk #(
  parameter int ST_W       = 3,
  parameter int LATE_FIRST = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fast_mode,
  input logic            bus_own_n,
  input logic [ST_W-1:0] bus_state,
  input logic            scsi_clk_en,
  input logic            dma_clk_en,
  input logic            ovr_req,
  input logic            ack_req,
  input logic            norm_tick,
  input logic            rate_sel
);

  localparam logic [ST_W-1:0] LATE_V = ST_W'(LATE_FIRST);

  p_dma_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_clk_en |=> !dma_clk_en);

  p_scsi_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scsi_clk_en |=> !scsi_clk_en);

  p_sel_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_sel) |-> $past(norm_tick));

  p_ovr_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_req |-> $past(!bus_own_n && fast_mode));

  p_ack_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> ($past(bus_state) >= LATE_V));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own_n |=> (!ovr_req && !ack_req));

endmodule

bind dma_rate_switch rate_switch_chk #(
  .ST_W       (ST_W),
  .LATE_FIRST (LATE_FIRST)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fast_mode   (fast_mode),
  .bus_own_n   (bus_own_n),
  .bus_state   (bus_state),
  .scsi_clk_en (scsi_clk_en),
  .dma_clk_en  (dma_clk_en),
  .ovr_req     (ovr_req),
  .ack_req     (ack_req),
  .norm_tick   (norm_tick),
  .rate_sel    (rate_sel)
);

// File: tb/dma_rate_switch_tb.sv
`timescale 1ns/1ps
module dma_rate_switch_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       ph_a = 1'b0, ph_b = 1'b0, ph_c = 1'b0;
  logic       fast_mode = 1'b0, bus_rd = 1'b1, bus_own_n = 1'b1;
  logic [2:0] addr_hi = '0, bus_state = '0;
  logic       scsi_clk_en, dma_clk_en, ovr_req, ack_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_rate_switch u_dut (
    .clk(clk), .rst_n(rst_n), .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
    .fast_mode(fast_mode), .bus_rd(bus_rd), .bus_own_n(bus_own_n),
    .addr_hi(addr_hi), .bus_state(bus_state),
    .scsi_clk_en(scsi_clk_en), .dma_clk_en(dma_clk_en),
    .ovr_req(ovr_req), .ack_req(ack_req)
  );

  // Phase generator: normal period = 4 clocks
  int tk = 0;
  initial forever begin
    @(negedge clk);
    ph_a = (tk % 8) < 4;
    ph_b = ((tk % 8) < 2) || ((tk % 8) >= 6);
    ph_c = ((tk % 4) == 0) || ((tk % 4) == 3);
    tk++;
  end

  // Output sampler
  int  sidx = 0, last_p = -1, gap_bad = 0, dbl_hi = 0, sc_cnt = 0, dm_cnt = 0;
  bit  trk = 0;
  logic prev_dm = 1'b0, prev_sc = 1'b0;
  initial forever begin
    @(negedge clk);
    sidx++;
    if (scsi_clk_en) sc_cnt++;
    if (dma_clk_en) begin
      dm_cnt++;
      if (trk && last_p >= 0 && (sidx - last_p) != 2 && (sidx - last_p) != 4) gap_bad++;
      last_p = sidx;
    end
    if (trk && ((dma_clk_en && prev_dm) || (scsi_clk_en && prev_sc))) dbl_hi++;
    prev_dm = dma_clk_en;
    prev_sc = scsi_clk_en;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_neg();
    @(negedge clk);
    #1;
  endtask

  task automatic set_bus(input logic j, input logic own, input logic rd,
                         input logic [2:0] rg, input logic [2:0] st);
    fast_mode = j; bus_own_n = own; bus_rd = rd; addr_hi = rg; bus_state = st;
  endtask

  // {mode, own_n, rd, region, state, scsi count, dma count, ovr, ack}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 3'd2, 3'd5, 6'd8,  6'd8,  1'b0, 1'b0},
    {1'b1, 1'b1, 1'b0, 3'd2, 3'd5, 6'd16, 6'd8,  1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 3'd2, 3'd5, 6'd16, 6'd16, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b1, 3'd2, 3'd5, 6'd16, 6'd8,  1'b1, 1'b1},
    {1'b1, 1'b0, 1'b0, 3'd0, 3'd5, 6'd16, 6'd8,  1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 3'd5, 3'd5, 6'd16, 6'd8,  1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 3'd1, 3'd2, 6'd16, 6'd8,  1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 3'd4, 3'd7, 6'd16, 6'd16, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b0, 3'd1, 3'd4, 6'd16, 6'd16, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b0, 3'd3, 3'd3, 6'd16, 6'd8,  1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 3'd7, 3'd6, 6'd16, 6'd8,  1'b0, 1'b0},
    {1'b0, 1'b0, 1'b1, 3'd1, 3'd6, 6'd8,  6'd8,  1'b0, 1'b0}
  };

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (8) wait_neg();
    // R1: quiet under reset
    chk("R1 scsi_clk_en", scsi_clk_en, 0);
    chk("R1 dma_clk_en", dma_clk_en, 0);
    chk("R1 ovr_req", ovr_req, 0);
    chk("R1 ack_req", ack_req, 0);
    rst_n = 1'b1;
    repeat (12) wait_neg();
    trk = 1;

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      set_bus(v[22], v[21], v[20], v[19:17], v[16:14]);
      repeat (12) wait_neg();
      sc_cnt = 0; dm_cnt = 0;
      repeat (32) wait_neg();
      chk(v[22] ? "R3 scsi rate" : "R2 scsi rate", sc_cnt, int'(v[13:8]));
      chk(v[7:2] == 6'd16 ? "R4 dma rate" : (v[22] ? "R5 dma rate" : "R2 dma rate"),
          dm_cnt, int'(v[7:2]));
      chk("R7 ovr_req", ovr_req, v[1]);
      chk("R8 ack_req", ack_req, v[0]);
    end

    // R6: double-rate request raised in mid-period
    set_bus(1'b1, 1'b0, 1'b0, 3'd2, 3'd2);
    repeat (12) wait_neg();
    while (((tk - 1) % 4) != 2) wait_neg();
    bus_state = 3'd5;
    repeat (2) wait_neg();
    chk("R6 no mid pulse", dma_clk_en, 0);
    repeat (2) wait_neg();
    chk("R6 boundary pulse", dma_clk_en, 1);
    repeat (2) wait_neg();
    chk("R6 double from next period", dma_clk_en, 1);

    // R8: acknowledge rises on entering state 4
    bus_state = 3'd3;
    repeat (4) wait_neg();
    chk("R8 ack before S4", ack_req, 0);
    bus_state = 3'd4;
    repeat (2) wait_neg();
    chk("R8 ack at S4", ack_req, 1);

    // R9: release when ownership ends
    bus_own_n = 1'b1;
    repeat (4) wait_neg();
    chk("R9 ovr released", ovr_req, 0);
    chk("R9 ack released", ack_req, 0);
    // R9: ack released when state wraps, override held (R7)
    bus_own_n = 1'b0; bus_state = 3'd6;
    repeat (4) wait_neg();
    bus_state = 3'd0;
    repeat (4) wait_neg();
    chk("R9 ack released at S0", ack_req, 0);
    chk("R7 ovr held at S0", ovr_req, 1);

    chk("R6 pulse spacing", gap_bad, 0);
    chk("R10 single-clock pulses", dbl_hi, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule